// File: doc/BRIEF.md
# Multi-channel thermometer observation encoder

The block turns a vector of signed fixed-point sensor observations into one wide thermometer bit vector for a downstream lookup-table logic network. Every channel first has a stored offset subtracted and is multiplied by a stored reciprocal spread. The result is then saturated to a symmetric bound and compared against a small ordered set of stored thresholds. An odd number of thresholds is used per channel. The middle one sits at normalized zero, so its bit acts as a sign test. The others spread out quadratically, which puts them closer together near zero than in the tails.

The offsets, reciprocals and thresholds are computed offline. They come up at reset with default values and can be replaced through a single-word write port. The hardware never changes them by itself. The code vector is registered and appears one clock after a qualified observation, together with a matching valid flag.

Top module: `thermo_obs_encoder`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_code` is all zeros.
- R2: With Q8 fixed point (FRAC = 8), each channel value is n = ((x − offset) × recip) >>> 8, using arithmetic (floor) shift and full-width products, before the R3 limit is applied.
- R3: n is saturated to the range [−CLIP, +CLIP], which is [−1024, +1024] by default, so a large input yields exactly ±CLIP.
- R4: Bit i of a channel is 1 exactly when n is strictly greater than threshold i. A value equal to a threshold gives 0 for that bit.
- R5: Channel c occupies `out_code[c*NTHR +: NTHR]`, with channel 0 in the least significant bits. Within a channel, bit i belongs to threshold index i.
- R6: `out_valid` equals `in_valid` delayed by one clock. A code captured at a clock edge reflects the observation present at that edge.
- R7: While `in_valid` is 0, `out_code` holds its previous value.
- R8: At reset every offset is 0 and every reciprocal is 256 (1.0). Each channel's thresholds are −918, −408, −102, 0, 102, 408, 918 for index 0 to 6. The middle threshold is zero and the spacing is denser near zero.
- R9: The write port encodes `cfg_kind` as 0 = offset, 1 = reciprocal and 2 = threshold. A write takes effect from the next clock, so an observation in the same cycle uses the old value. Kind 3, a channel index ≥ NCH, or a threshold index ≥ NTHR changes nothing, and without a write no stored constant changes.
- R10: When a channel's thresholds are strictly ascending, its code is a thermometer: its ones are contiguous from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Observation vector qualifier |
| in_obs | input | NCH*OBS_W | Signed observations, channel c at [c*OBS_W +: OBS_W] |
| cfg_we | input | 1 | Constant write strobe |
| cfg_kind | input | 2 | Target kind: 0 offset, 1 reciprocal, 2 threshold, 3 none |
| cfg_ch | input | CHW | Channel index of the write |
| cfg_idx | input | TIW | Threshold index of the write |
| cfg_data | input | OBS_W | Signed value written |
| out_valid | output | 1 | Code qualifier, one clock after in_valid |
| out_code | output | NCH*NTHR | Concatenated thermometer codes |

## Verification
The thermometer-shape assertion only makes a claim when a channel's thresholds are strictly ascending. The saturation check assumes that CLIP is positive and below the signed observation range. All other assertions assume only that the inputs are known once reset is released.

The directed part of the stimulus writes thresholds that keep ascending order. It does this so that shape checks and exact-equality cases can be read directly. The random phase writes arbitrary offsets, reciprocals and thresholds, including unordered ones, ignored kinds and out-of-range indices. That phase depends on the guarded shape assertion and on the bench's behavioural model for every other property.

// File: rtl/tenc_pkg.sv
package tenc_pkg;

  typedef enum logic [1:0] {
    CFG_OFFSET = 2'd0,
    CFG_RECIP  = 2'd1,
    CFG_THRESH = 2'd2,
    CFG_NONE   = 2'd3
  } cfg_kind_e;

  // Default threshold for index idx: quadratic spacing around zero,
  // outermost magnitude kept below the clip bound.
  function automatic int default_thr(input int idx, input int nthr, input int clip);
    int half;
    int k;
    int step;
    half = nthr / 2;
    k    = idx - half;
    step = clip / (half * half + 1);
    return (k < 0) ? -(k * k * step) : (k * k * step);
  endfunction

endpackage

// File: rtl/tenc_cfg_store.sv
module tenc_cfg_store
  import tenc_pkg::*;
#(
  parameter int NCH   = 3,
  parameter int OBS_W = 16,
  parameter int FRAC  = 8,
  parameter int NTHR  = 7,
  parameter int CLIP  = 1024,
  parameter int CHW   = (NCH > 1) ? $clog2(NCH) : 1,
  parameter int TIW   = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  cfg_we,
  input  logic [1:0]                            cfg_kind,
  input  logic [CHW-1:0]                        cfg_ch,
  input  logic [TIW-1:0]                        cfg_idx,
  input  logic [OBS_W-1:0]                      cfg_data,
  output logic [NCH-1:0][OBS_W-1:0]             offset_o,
  output logic [NCH-1:0][OBS_W-1:0]             recip_o,
  output logic [NCH-1:0][NTHR-1:0][OBS_W-1:0]   thr_o
);

  localparam logic [OBS_W-1:0] UNIT_RECIP = OBS_W'(1 << FRAC);

  logic [NCH-1:0][OBS_W-1:0]           offset_q, offset_d;
  logic [NCH-1:0][OBS_W-1:0]           recip_q,  recip_d;
  logic [NCH-1:0][NTHR-1:0][OBS_W-1:0] thr_q,    thr_d;
  logic                                upd_en;

  assign upd_en = cfg_we;

  always_comb begin
    offset_d = offset_q;
    recip_d  = recip_q;
    thr_d    = thr_q;
    for (int c = 0; c < NCH; c++) begin
      if (cfg_we && (int'(cfg_ch) == c)) begin
        case (cfg_kind_e'(cfg_kind))
          CFG_OFFSET: offset_d[c] = cfg_data;
          CFG_RECIP:  recip_d[c]  = cfg_data;
          CFG_THRESH: begin
            for (int i = 0; i < NTHR; i++) begin
              if (int'(cfg_idx) == i) thr_d[c][i] = cfg_data;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        offset_q[c] <= '0;
        recip_q[c]  <= UNIT_RECIP;
        for (int i = 0; i < NTHR; i++) begin
          thr_q[c][i] <= OBS_W'(default_thr(i, NTHR, CLIP));
        end
      end
    end else if (upd_en) begin
      offset_q <= offset_d;
      recip_q  <= recip_d;
      thr_q    <= thr_d;
    end
  end

  assign offset_o = offset_q;
  assign recip_o  = recip_q;
  assign thr_o    = thr_q;

  // R9: thresholds never move without an explicit write
  assert_thr_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(thr_q));

  // R9: a write of the unused kind leaves every constant untouched
  assert_kind_ignored_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_kind == 2'd3) |=>
      ($stable(thr_q) && $stable(offset_q) && $stable(recip_q)));

endmodule

// File: rtl/tenc_norm.sv
module tenc_norm #(
  parameter int OBS_W = 16,
  parameter int FRAC  = 8,
  parameter int CLIP  = 1024
) (
  input  logic signed [OBS_W-1:0] obs,
  input  logic signed [OBS_W-1:0] offset,
  input  logic signed [OBS_W-1:0] recip,
  output logic signed [OBS_W-1:0] norm
);

  localparam int DW = OBS_W + 1;
  localparam int PW = DW + OBS_W;
  localparam logic signed [PW-1:0] HI = PW'(CLIP);
  localparam logic signed [PW-1:0] LO = -HI;

  logic signed [DW-1:0] diff;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] scaled;

  always_comb begin
    diff   = DW'(obs) - DW'(offset);
    prod   = PW'(diff) * PW'(recip);
    scaled = prod >>> FRAC;
    if (scaled > HI) begin
      norm = OBS_W'(CLIP);
    end else if (scaled < LO) begin
      norm = OBS_W'(-CLIP);
    end else begin
      norm = scaled[OBS_W-1:0];
    end
  end

endmodule

// File: rtl/tenc_thermo.sv
module tenc_thermo #(
  parameter int OBS_W = 16,
  parameter int NTHR  = 7
) (
  input  logic signed [OBS_W-1:0]      norm,
  input  logic [NTHR-1:0][OBS_W-1:0]   thr,
  output logic [NTHR-1:0]              code
);

  for (genvar i = 0; i < NTHR; i++) begin : g_cmp
    assign code[i] = (norm > $signed(thr[i]));
  end

endmodule

// File: rtl/thermo_obs_encoder.sv
module thermo_obs_encoder #(
  parameter int NCH   = 3,
  parameter int OBS_W = 16,
  parameter int FRAC  = 8,
  parameter int NTHR  = 7,
  parameter int CLIP  = 1024,
  localparam int CHW    = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int TIW    = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int CODE_W = NCH * NTHR
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [NCH*OBS_W-1:0]   in_obs,
  input  logic                   cfg_we,
  input  logic [1:0]             cfg_kind,
  input  logic [CHW-1:0]         cfg_ch,
  input  logic [TIW-1:0]         cfg_idx,
  input  logic [OBS_W-1:0]       cfg_data,
  output logic                   out_valid,
  output logic [CODE_W-1:0]      out_code
);

  logic [NCH-1:0][OBS_W-1:0]           offset_w;
  logic [NCH-1:0][OBS_W-1:0]           recip_w;
  logic [NCH-1:0][NTHR-1:0][OBS_W-1:0] thr_w;
  logic [NCH-1:0][OBS_W-1:0]           norm_w;
  logic [CODE_W-1:0]                   code_comb;

  logic [CODE_W-1:0] code_q, code_d;
  logic              valid_q, valid_d;
  logic              code_en;

  tenc_cfg_store #(
    .NCH(NCH), .OBS_W(OBS_W), .FRAC(FRAC), .NTHR(NTHR), .CLIP(CLIP),
    .CHW(CHW), .TIW(TIW)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_kind (cfg_kind),
    .cfg_ch   (cfg_ch),
    .cfg_idx  (cfg_idx),
    .cfg_data (cfg_data),
    .offset_o (offset_w),
    .recip_o  (recip_w),
    .thr_o    (thr_w)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tenc_norm #(.OBS_W(OBS_W), .FRAC(FRAC), .CLIP(CLIP)) u_norm (
      .obs    (in_obs[c*OBS_W +: OBS_W]),
      .offset (offset_w[c]),
      .recip  (recip_w[c]),
      .norm   (norm_w[c])
    );

    tenc_thermo #(.OBS_W(OBS_W), .NTHR(NTHR)) u_thermo (
      .norm (norm_w[c]),
      .thr  (thr_w[c]),
      .code (code_comb[c*NTHR +: NTHR])
    );

    // R3: the normalized value never leaves the clip range
    assert_clip_range_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      ($signed(norm_w[c]) <= CLIP) && ($signed(norm_w[c]) >= -CLIP));
  end

  // Output stage: next-state and register processes
  assign code_en = in_valid;

  always_comb begin
    code_d  = code_q;
    valid_d = in_valid;
    if (code_en) code_d = code_comb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      code_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (code_en) code_q <= code_d;
    end
  end

  assign out_valid = valid_q;
  assign out_code  = code_q;

  // Observation helpers for the checks below
  logic thr_ascending;
  logic code_is_thermo;

  always_comb begin
    thr_ascending = 1'b1;
    for (int c = 0; c < NCH; c++) begin
      for (int i = 1; i < NTHR; i++) begin
        if ($signed(thr_w[c][i]) <= $signed(thr_w[c][i-1])) thr_ascending = 1'b0;
      end
    end
  end

  always_comb begin
    code_is_thermo = 1'b1;
    for (int c = 0; c < NCH; c++) begin
      for (int i = 1; i < NTHR; i++) begin
        if (out_code[c*NTHR + i] && !out_code[c*NTHR + i - 1]) code_is_thermo = 1'b0;
      end
    end
  end

  // R6: a valid output always follows a valid input by one clock
  assert_valid_follows_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R6: a valid input always produces a valid output next clock
  assert_valid_latency_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R7: idle cycles leave the code untouched
  assert_code_hold_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_code));

  // R10: ordered thresholds give contiguous ones from bit 0
  assert_thermo_shape_R10 : assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && thr_ascending) |=> code_is_thermo);

endmodule

// File: tb/test_thermo_obs_encoder.sv
module test_thermo_obs_encoder;

  localparam int NCH    = 3;
  localparam int OBS_W  = 16;
  localparam int FRAC   = 8;
  localparam int NTHR   = 7;
  localparam int CLIP   = 1024;
  localparam int CODE_W = NCH * NTHR;

  logic                 clk;
  logic                 rst_n;
  logic                 in_valid;
  logic [NCH*OBS_W-1:0] in_obs;
  logic                 cfg_we;
  logic [1:0]           cfg_kind;
  logic [1:0]           cfg_ch;
  logic [2:0]           cfg_idx;
  logic [OBS_W-1:0]     cfg_data;
  logic                 out_valid;
  logic [CODE_W-1:0]    out_code;

  thermo_obs_encoder i_thermo_obs_encoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_obs(in_obs),
    .cfg_we(cfg_we), .cfg_kind(cfg_kind), .cfg_ch(cfg_ch), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .out_valid(out_valid), .out_code(out_code)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Behavioural model state
  int m_off [NCH];
  int m_rcp [NCH];
  int m_thr [NCH][NTHR];
  bit                exp_valid;
  logic [CODE_W-1:0] exp_code;
  bit                exp_hold;

  // Pending literal check, evaluated one clock after the probe drive
  bit                pend_en;
  int                pend_ch;
  logic [CODE_W-1:0] pend_val;
  string             pend_tag;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [CODE_W-1:0] model_code(input int o0, input int o1, input int o2);
    logic [CODE_W-1:0] r;
    int obs [NCH];
    longint d, p, s;
    obs[0] = o0; obs[1] = o1; obs[2] = o2;
    r = '0;
    for (int c = 0; c < NCH; c++) begin
      d = longint'(obs[c]) - longint'(m_off[c]);
      p = d * longint'(m_rcp[c]);
      s = p >>> FRAC;
      if (s > CLIP) s = CLIP;
      if (s < -CLIP) s = -CLIP;
      for (int i = 0; i < NTHR; i++) r[c*NTHR + i] = (s > longint'(m_thr[c][i]));
    end
    return r;
  endfunction

  task automatic cyc(input bit v, input int o0, input int o1, input int o2,
                     input bit we, input int kind, input int ch, input int idx, input int data);
    logic [OBS_W-1:0] dv;
    @(negedge clk);
    chk(out_valid == exp_valid, "R6 out_valid", 64'(out_valid), 64'(exp_valid));
    chk(out_code == exp_code, exp_hold ? "R7 held code" : "R2 R4 code",
        64'(out_code), 64'(exp_code));
    if (pend_en) begin
      if (pend_ch < 0)
        chk(out_code == pend_val, pend_tag, 64'(out_code), 64'(pend_val));
      else
        chk(out_code[pend_ch*NTHR +: NTHR] == pend_val[NTHR-1:0], pend_tag,
            64'(out_code[pend_ch*NTHR +: NTHR]), 64'(pend_val[NTHR-1:0]));
      pend_en = 0;
    end
    in_valid = v;
    in_obs[0*OBS_W +: OBS_W] = OBS_W'(o0);
    in_obs[1*OBS_W +: OBS_W] = OBS_W'(o1);
    in_obs[2*OBS_W +: OBS_W] = OBS_W'(o2);
    cfg_we   = we;
    cfg_kind = 2'(kind);
    cfg_ch   = 2'(ch);
    cfg_idx  = 3'(idx);
    dv       = OBS_W'(data);
    cfg_data = dv;
    exp_valid = v;
    exp_hold  = !v;
    if (v) exp_code = model_code(o0, o1, o2);
    if (we && kind < 3 && ch < NCH) begin
      if (kind == 0) m_off[ch] = int'($signed(dv));
      else if (kind == 1) m_rcp[ch] = int'($signed(dv));
      else if (idx < NTHR) m_thr[ch][idx] = int'($signed(dv));
    end
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic wr(input int kind, input int ch, input int idx, input int data);
    cyc(0, 0, 0, 0, 1, kind, ch, idx, data);
  endtask

  task automatic probe(input int o0, input int o1, input int o2, input int ch,
                       input logic [CODE_W-1:0] val, input string tag);
    cyc(1, o0, o1, o2, 0, 0, 0, 0, 0);
    pend_en = 1; pend_ch = ch; pend_val = val; pend_tag = tag;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int dflt [NTHR];
    dflt = '{-918, -408, -102, 0, 102, 408, 918};
    for (int c = 0; c < NCH; c++) begin
      m_off[c] = 0;
      m_rcp[c] = 256;
      for (int i = 0; i < NTHR; i++) m_thr[c][i] = dflt[i];
    end
    exp_valid = 0; exp_code = '0; exp_hold = 0; pend_en = 0;
    pend_ch = 0; pend_val = '0; pend_tag = "";
    rst_n = 0; in_valid = 0; in_obs = '0; cfg_we = 0; cfg_kind = 0;
    cfg_ch = 0; cfg_idx = 0; cfg_data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset valid", 64'(out_valid), 64'd0);
    chk(out_code == '0, "R1 reset code", 64'(out_code), 64'd0);
    rst_n = 1;

    // R8 / R4 with default constants (offset 0, recip 1.0 so n = x)
    probe(0, 0, 0, 0, 7'h07, "R8 middle threshold zero");
    probe(102, 0, 0, 0, 7'h0F, "R4 equal threshold gives 0");
    probe(103, 0, 0, 0, 7'h1F, "R4 just above threshold");
    probe(-1, 0, 0, 0, 7'h07, "R8 negative near zero");
    probe(-917, 0, 0, 0, 7'h01, "R8 lowest threshold");
    probe(918, 0, 0, 0, 7'h3F, "R8 outer threshold equal");
    probe(5000, 0, 0, 0, 7'h7F, "R3 clip high");
    probe(-30000, 0, 0, 0, 7'h00, "R3 clip low");

    // R7: idle cycles keep the last code
    idle();
    idle();
    chk(out_code[NTHR-1:0] == 7'h00, "R7 hold after idle", 64'(out_code[NTHR-1:0]), 64'd0);

    // R2: offset 256, recip 2.0 on channel 1
    wr(0, 1, 0, 256);
    wr(1, 1, 0, 512);
    probe(0, 384, 0, 1, 7'h1F, "R2 scaled value 256");
    probe(0, -100, 0, 1, 7'h01, "R2 scaled value -712");
    probe(0, 257, 0, 1, 7'h0F, "R2 scaled value 2");
    probe(0, 32767, 0, 1, 7'h7F, "R3 clip after scaling");

    // R5: channel placement in the concatenated vector
    probe(-30000, 0, 30000, -1,
          (CODE_W'(7'h7F) << (2*NTHR)) | (CODE_W'(7'h01) << NTHR), "R5 channel order");

    // R3: clip is exactly CLIP (threshold written at 1024 stays clear)
    wr(2, 0, 6, 1024);
    probe(5000, 0, 0, 0, 7'h3F, "R3 clip equals bound");
    wr(2, 0, 6, 918);

    // R9: write timing and ignored writes
    cyc(1, 40, 0, 0, 1, 2, 0, 3, 50);
    pend_en = 1; pend_ch = 0; pend_val = 7'h0F; pend_tag = "R9 write uses old value";
    probe(40, 0, 0, 0, 7'h07, "R9 write visible next clock");
    wr(3, 0, 3, 500);
    wr(2, 3, 3, 500);
    wr(2, 0, 7, 500);
    probe(45, 0, 0, 0, 7'h07, "R9 ignored writes");
    probe(200, 0, 0, 0, 7'h1F, "R9 thresholds unchanged");

    // R10: contiguous ones across a sweep with ordered thresholds
    for (int x = -1100; x <= 1100; x += 37) begin
      cyc(1, x, x, -x, 0, 0, 0, 0, 0);
    end
    idle();

    // Random phase: model comparison on every clock
    for (int n = 0; n < 3000; n++) begin
      bit v;
      bit we;
      v  = 1'($urandom_range(0, 1));
      we = ($urandom_range(0, 7) == 0);
      cyc(v, int'($urandom_range(0, 65535)) - 32768,
             int'($urandom_range(0, 2047)) - 1024,
             int'($urandom_range(0, 65535)) - 32768,
          we, int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
          int'($urandom_range(0, 7)), int'($urandom_range(0, 65535)) - 32768);
    end
    idle();
    idle();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule